// File: doc/BRIEF.md
# Strobed Overvoltage Run Filter

This block turns a noisy overvoltage comparator flag into a clean fault decision for a switching power stage. The flag reports whether the divided auxiliary-winding voltage sits above the overvoltage reference. That voltage only follows the output while the power switch is off, and it rings just after turn-off. For these reasons the block looks at the flag exactly once per off period, in a one-clock window placed a fixed number of clocks after the gate falls.

Every cycle-start strobe from the oscillator closes the switching cycle that just ended. If that cycle held an over-threshold sample, a run counter steps up. Otherwise the counter returns to zero. When the run reaches the trip length, a latched fault is raised. The fault tells the switching logic to stop and asks the restart supervisor for an auto-restart. Only that supervisor clears the fault, through a clear pulse.

Top module: `ovf_filter`

## Requirements
- R1: After a synchronous reset, `fault` is 0 and `run_count` is 0.
- R2: The flag is sampled only at the rising clock edge that comes exactly `BLANK_CLKS` edges after the first edge at which `gate_on` is seen low following a high. The gate must have stayed low the whole time. A high flag at any other edge has no effect on `run_count`.
- R3: If `gate_on` returns high at or before the sampling edge, that off period yields no sample, and the switching cycle counts as not triggered.
- R4: At an edge with `cyc_start` = 1, a closing cycle that holds an over-threshold sample raises `run_count` by one.
- R5: At an edge with `cyc_start` = 1, a closing cycle with no over-threshold sample sets `run_count` to 0.
- R6: `fault` becomes 1 at the edge where `run_count` reaches `TRIP_RUN` (4 by default). `run_count` saturates at `TRIP_RUN`.
- R7: Once set, `fault` stays 1 through clean cycles until `fault_clr` is 1 at an edge. That edge clears both `fault` and `run_count`, and it takes priority over a simultaneous `cyc_start`.
- R8: A switching cycle credits at most one step, even if several off periods inside it produce over-threshold samples.
- R9: A sample taken at the same edge as `cyc_start` is credited to the cycle that is closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_on | input | 1 | Power switch gate command, 1 = switch on |
| cyc_start | input | 1 | One-clock pulse at each oscillator cycle start |
| ov_flag | input | 1 | Comparator output, 1 = above overvoltage reference |
| fault_clr | input | 1 | One-clock clear from the restart supervisor |
| fault | output | 1 | Latched overvoltage fault |
| run_count | output | CNT_W | Consecutive triggered-cycle count |

## Verification
The bench builds the block with `BLANK_CLKS` = 5 and `TRIP_RUN` = 4. With this short blanking delay, an off period can be made to end one clock before the window, exactly at it, or after it, and a strobe can be lined up with a cycle start, all within a few clocks. A trip length of 4 means that saturation, the latched fault and the clear all appear within a few dozen cycles. A behavioural model counts low clocks since the gate fell and is compared with both outputs on every clock.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    // Blanking timer states
    typedef enum logic [0:0] {
        TMR_IDLE  = 1'b0,
        TMR_BLANK = 1'b1
    } tmr_state_e;

    // Next run length: saturating step on a triggered cycle, zero otherwise
    function automatic int unsigned run_step(input int unsigned cur,
                                             input int unsigned lim,
                                             input logic        hit);
        if (!hit)
            return 0;
        if (cur >= lim)
            return lim;
        return cur + 1;
    endfunction

    // Whether a run length has reached the trip length
    function automatic logic run_tripped(input int unsigned cur,
                                         input int unsigned lim);
        return (cur >= lim);
    endfunction

endpackage

// File: rtl/ovf_strobe_timer.sv
module ovf_strobe_timer
    import ovf_pkg::*;
#(
    parameter int BLANK_CLKS = 110,
    localparam int DLY_W = $clog2(BLANK_CLKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_on,
    output logic strobe
);

    logic             gate_q;
    tmr_state_e       state;
    logic [DLY_W-1:0] dly;

    assign strobe = (state == TMR_BLANK) && !gate_on && (dly == DLY_W'(BLANK_CLKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            state  <= TMR_IDLE;
            dly    <= '0;
        end else begin
            gate_q <= gate_on;
            if (gate_on) begin
                state <= TMR_IDLE;
            end else if (gate_q) begin
                state <= TMR_BLANK;
                dly   <= DLY_W'(1);
            end else if (state == TMR_BLANK) begin
                if (strobe)
                    state <= TMR_IDLE;
                else
                    dly <= dly + DLY_W'(1);
            end
        end
    end

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R3
    strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(!gate_on));

endmodule

// File: rtl/ovf_cycle_latch.sv
module ovf_cycle_latch (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic ov_flag,
    input  logic cyc_start,
    output logic closing_hit
);

    logic hit_now;
    logic held;

    assign hit_now     = strobe && ov_flag;
    assign closing_hit = held || hit_now;

    always_ff @(posedge clk) begin
        if (rst)
            held <= 1'b0;
        else if (cyc_start)
            held <= 1'b0;
        else if (hit_now)
            held <= 1'b1;
    end

    // R8
    held_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !hit_now) |=> !closing_hit || ($past(cyc_start) && strobe && ov_flag));

endmodule

// File: rtl/ovf_run_counter.sv
module ovf_run_counter
    import ovf_pkg::*;
#(
    parameter int TRIP_RUN = 4,
    localparam int CNT_W = $clog2(TRIP_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start,
    input  logic             closing_hit,
    input  logic             fault_clr,
    output logic [CNT_W-1:0] count,
    output logic             fault
);

    logic [CNT_W-1:0] count_nxt;
    logic             trip_nxt;

    always_comb begin
        count_nxt = CNT_W'(run_step(int'(unsigned'(count)), TRIP_RUN, closing_hit));
        trip_nxt  = run_tripped(int'(unsigned'(count_nxt)), TRIP_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            fault <= 1'b0;
        end else if (fault_clr) begin
            count <= '0;
            fault <= 1'b0;
        end else if (cyc_start) begin
            count <= count_nxt;
            if (trip_nxt)
                fault <= 1'b1;
        end
    end

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(TRIP_RUN));

    // R6
    fault_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> count == CNT_W'(TRIP_RUN));

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !fault_clr) |=> fault);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        fault_clr |=> (count == '0) && !fault);

    // R5
    clean_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !closing_hit && !fault_clr) |=> count == '0);

    // R4
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && closing_hit && !fault_clr && count < CNT_W'(TRIP_RUN))
            |=> count == $past(count) + CNT_W'(1));

endmodule

// File: rtl/ovf_filter.sv
module ovf_filter
    import ovf_pkg::*;
#(
    parameter int BLANK_CLKS = 110,
    parameter int TRIP_RUN   = 4,
    localparam int CNT_W = $clog2(TRIP_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_on,
    input  logic             cyc_start,
    input  logic             ov_flag,
    input  logic             fault_clr,
    output logic             fault,
    output logic [CNT_W-1:0] run_count
);

    logic strobe;
    logic closing_hit;

    ovf_strobe_timer #(
        .BLANK_CLKS(BLANK_CLKS)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .gate_on(gate_on),
        .strobe (strobe)
    );

    ovf_cycle_latch latch_i (
        .clk        (clk),
        .rst        (rst),
        .strobe     (strobe),
        .ov_flag    (ov_flag),
        .cyc_start  (cyc_start),
        .closing_hit(closing_hit)
    );

    ovf_run_counter #(
        .TRIP_RUN(TRIP_RUN)
    ) counter_i (
        .clk        (clk),
        .rst        (rst),
        .cyc_start  (cyc_start),
        .closing_hit(closing_hit),
        .fault_clr  (fault_clr),
        .count      (run_count),
        .fault      (fault)
    );

    // R9
    strobe_credit_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && ov_flag && cyc_start && !fault_clr && run_count == '0)
            |=> run_count == CNT_W'(1));

endmodule

// File: tb/ovf_filter_tb_top.sv
module ovf_filter_tb_top;

    localparam int B     = 5;
    localparam int TRIP  = 4;
    localparam int CW    = $clog2(TRIP + 1);
    localparam int LIMIT = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gate_on = 1'b0;
    logic cyc_start = 1'b0;
    logic ov_flag = 1'b0;
    logic fault_clr = 1'b0;
    logic          fault;
    logic [CW-1:0] run_count;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    ovf_filter #(.BLANK_CLKS(B), .TRIP_RUN(TRIP)) dut_i (
        .clk(clk), .rst(rst), .gate_on(gate_on), .cyc_start(cyc_start),
        .ov_flag(ov_flag), .fault_clr(fault_clr),
        .fault(fault), .run_count(run_count)
    );

    // Behavioural reference model
    int m_cnt = 0;
    bit m_fault = 0;
    bit m_pend = 0;
    bit m_seen_high = 0;
    int m_low_run = 0;

    always @(posedge clk) begin
        bit samp;
        bit hit;
        bit closing;
        if (rst) begin
            m_cnt = 0; m_fault = 0; m_pend = 0; m_seen_high = 0; m_low_run = 0;
        end else begin
            samp    = !gate_on && m_seen_high && (m_low_run == B);
            hit     = samp && ov_flag;
            closing = m_pend || hit;
            if (fault_clr) begin
                m_cnt = 0; m_fault = 0;
            end else if (cyc_start) begin
                if (closing) begin
                    m_cnt = (m_cnt + 1 > TRIP) ? TRIP : m_cnt + 1;
                    if (m_cnt == TRIP) m_fault = 1;
                end else begin
                    m_cnt = 0;
                end
            end
            if (cyc_start)  m_pend = 0;
            else if (hit)   m_pend = 1;
            if (gate_on) begin
                m_seen_high = 1; m_low_run = 0;
            end else if (m_seen_high && m_low_run <= B) begin
                m_low_run++;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst && !done) begin
                check("R4 R5 run_count vs model", int'(run_count), m_cnt);
                check("R6 fault vs model", int'(fault), int'(m_fault));
            end
        end
    end

    // One switching cycle: on for 3 clocks, then off for 'off' clocks
    task automatic cyc(input bit fs, input bit fe, input int off = B + 2, input bit st = 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cyc_start = st && (i == 0);
            gate_on = 1'b1;
            ov_flag = fe;
        end
        for (int j = 0; j < off; j++) begin
            @(negedge clk);
            cyc_start = 1'b0;
            gate_on = 1'b0;
            ov_flag = (j == B) ? fs : fe;
        end
    endtask

    // Start of a new cycle with gate held low; fl drives the flag at that edge
    task automatic close(input bit fl = 0, input bit clr = 0);
        @(negedge clk);
        cyc_start = 1'b1; gate_on = 1'b0; ov_flag = fl; fault_clr = clr;
        @(negedge clk);
        cyc_start = 1'b0; ov_flag = 1'b0; fault_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(run_count), 0);
        check("R1 reset fault", int'(fault), 0);
        rst = 1'b0;

        // R2: flag high everywhere except the window
        repeat (3) cyc(1'b0, 1'b1);
        close();
        check("R2 off-window flag ignored", int'(run_count), 0);

        // R4: consecutive triggered cycles
        repeat (3) cyc(1'b1, 1'b0);
        close();
        check("R4 three steps", int'(run_count), 3);
        check("R4 no fault yet", int'(fault), 0);

        // R5: clean cycle restarts the run
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b1, 1'b0);
        close();
        check("R5 run restarted", int'(run_count), 1);

        // R3: gate back on at the window edge
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b1, B); cyc(1'b1, 1'b0);
        close();
        check("R3 short off period untriggered", int'(run_count), 1);

        // R8: two triggered off periods inside one cycle
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0, B + 2, 1'b0);
        close();
        check("R8 single credit per cycle", int'(run_count), 1);

        // R9: strobe coincides with cycle start
        cyc(1'b0, 1'b0, B);
        close(1'b1);
        check("R9 coincident strobe credited", int'(run_count), 1);

        // R6: trip and saturate
        repeat (6) cyc(1'b1, 1'b0);
        close();
        check("R6 saturated count", int'(run_count), TRIP);
        check("R6 fault set", int'(fault), 1);

        // R7: fault holds through clean cycles
        repeat (2) cyc(1'b0, 1'b0);
        close();
        check("R7 count cleared by clean cycle", int'(run_count), 0);
        check("R7 fault held", int'(fault), 1);

        // R7: clear pulse
        @(negedge clk); fault_clr = 1'b1;
        @(negedge clk); fault_clr = 1'b0;
        check("R7 clear fault", int'(fault), 0);
        check("R7 clear count", int'(run_count), 0);

        // R7: clear beats simultaneous cycle start
        repeat (3) cyc(1'b1, 1'b0);
        close(1'b0, 1'b1);
        check("R7 clear priority", int'(run_count), 0);
        cyc(1'b1, 1'b0);
        close();
        check("R7 run restarts after clear", int'(run_count), 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule